// File: doc/BRIEF.md
# PLL Feedback Multiplier Codec

This block converts between a binary PLL feedback multiplier and the 17-bit shift-register code that the PLL's feedback divider takes. An encode request turns a multiplier into its code. It also works out the proportional and integral loop-bandwidth fields for that multiplier and returns all three packed into one configuration word. A decode request turns a code back into its multiplier and also gives the PLL output-to-input frequency ratio, which is twice the multiplier.

The code is a 15-bit linear-feedback state. It is reached from a fixed seed by a number of steps that depends on the multiplier, so a conversion walks the register one step at a time. The block does `LANES` steps per clock, and the default of one step per clock gives a worst case of about 32 thousand cycles. Multipliers 0, 1 and 2, and the two codes reserved for 1 and 2, finish without any walk.

A caller pulses `start` with `mode` and `din`, then waits for the single-cycle `done`. The results are valid on that cycle and stay on the outputs until the next result.

Top module: `pll_mult_codec`

## Requirements
- R1: While reset is low and after it is released, `done`, `dout`, `factor` and `bad` are all zero.
- R2: Encode (`mode`=0, multiplier in `din[15:0]`) of 0, 1 and 2 gives the codes 0, 0x18003 and 0x10003, with `done` on the clock edge right after the one that takes `start`.
- R3: Encode of a multiplier M from 3 to 32768 gives the state reached from 0x4000 after 32769−M steps. Each step is x ← {x[0]^x[1], x[14:1]}, with bits 16:15 of the code zero.
- R4: The encode word holds the code in bits 16:0. Bits 21:17 hold the proportional field, which is (M>>1)+1 for M<60 and 31 otherwise.
- R5: Bits 27:22 of the encode word hold the integral field, and bits 31:28 are zero. The integral field is 1 for M>16384, 2 for M>8192, 4 for M>2048 and 8 for M≥501. For 60≤M≤500 it is 4·⌈1024/(M+9)⌉, and below 60 it is (M & 0x3C)+4. On encode `factor` is 0.
- R6: Decode (`mode`=1, code in `din`) of 0x18003 gives 1 and of 0x10003 gives 2, each one edge after `start`.
- R7: Any other decode steps x ← {x[13:0], x[14]^x[0]} from `din` while a counter that starts at 32769 falls by one per step. The walk stops when x equals 0x4000 or the counter reaches zero. The final counter value is placed in `dout[15:0]`, with `dout[31:16]` zero.
- R8: On a valid decode, `factor` equals twice the decoded multiplier.
- R9: A decode that exhausts the counter without reaching 0x4000 sets `bad` and drives `dout` and `factor` to zero.
- R10: `done` lasts exactly one cycle. A `start` while a conversion is running, or on the cycle that `done` is high, is ignored and produces no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a conversion |
| mode | input | 1 | 0 = encode multiplier, 1 = decode code |
| din | input | 17 | Multiplier (bits 15:0) or code (bits 16:0) |
| done | output | 1 | One-cycle result strobe |
| dout | output | 32 | Packed encode word, or decoded multiplier |
| factor | output | 17 | Frequency ratio 2·M after a decode |
| bad | output | 1 | Decode found no valid multiplier |

## Verification
The bench goes after the bandwidth thresholds at 59/60, 500/501 and above 2048. A wrong comparison or rounding direction there gives a wrong field while the code stays correct. It round-trips multipliers near both ends of the range: an off-by-one in the step count moves every code, and at 32768 it would show up as a seed or a doubled step. It feeds the all-zero code, which never reaches the seed, so a design that forgot the counter limit would hang or report a false multiplier. It also fires extra starts in the middle of a walk and on the `done` cycle, where a design that accepted them would raise a stray `done`.

// File: rtl/pll_codec_pkg.sv
package pll_codec_pkg;
    localparam int CODE_W  = 17;
    localparam int CNT_W   = 16;
    localparam int WORD_W  = 32;
    localparam int FACT_W  = CNT_W + 1;
    localparam int PROP_W  = 5;
    localparam int INTEG_W = 6;

    localparam logic [CODE_W-1:0] SEED      = 17'h04000;
    localparam logic [CODE_W-1:0] CODE_M1   = 17'h18003;
    localparam logic [CODE_W-1:0] CODE_M2   = 17'h10003;
    localparam logic [CNT_W-1:0]  MULT_TOP  = 16'd32768;
    localparam logic [CNT_W-1:0]  CNT_START = 16'd32769;

    typedef enum logic {ST_IDLE, ST_RUN} state_e;

    typedef struct packed {
        state_e              st;
        logic                dec;
        logic [CNT_W-1:0]    mult;
        logic [CODE_W-1:0]   x;
        logic [CNT_W-1:0]    cnt;
        logic                done;
        logic [WORD_W-1:0]   dout;
        logic [FACT_W-1:0]   factor;
        logic                bad;
    } regs_t;

    function automatic logic [WORD_W-1:0] pack_word(input logic [CODE_W-1:0] code,
                                                    input logic [PROP_W-1:0] prop,
                                                    input logic [INTEG_W-1:0] integ);
        return {4'b0000, integ, prop, code};
    endfunction
endpackage

// File: rtl/pll_codec_lane.sv
module pll_codec_lane
    import pll_codec_pkg::*;
(
    input  logic              dec,
    input  logic [CODE_W-1:0] x_in,
    input  logic [CNT_W-1:0]  cnt_in,
    output logic [CODE_W-1:0] x_out,
    output logic [CNT_W-1:0]  cnt_out
);
    logic              halt;
    logic [CODE_W-1:0] fwd;
    logic [CODE_W-1:0] bwd;

    always_comb begin
        halt    = (cnt_in == '0) || (dec && (x_in == SEED));
        fwd     = {2'b00, x_in[0] ^ x_in[1], x_in[14:1]};
        bwd     = {2'b00, x_in[13:0], x_in[14] ^ x_in[0]};
        x_out   = halt ? x_in : (dec ? bwd : fwd);
        cnt_out = halt ? cnt_in : cnt_in - 1'b1;
    end
endmodule

// File: rtl/pll_codec_bw.sv
module pll_codec_bw
    import pll_codec_pkg::*;
(
    input  logic [CNT_W-1:0]   mult,
    output logic [PROP_W-1:0]  prop,
    output logic [INTEG_W-1:0] integ
);
    logic [10:0] den;
    logic [10:0] quo;

    always_comb begin
        den = 11'(mult[8:0]) + 11'd9;
        quo = (11'd1023 + den) / den;

        if (mult < 16'd60) prop = 5'(mult[5:1]) + 5'd1;
        else               prop = 5'd31;

        if (mult > 16'd16384)     integ = 6'd1;
        else if (mult > 16'd8192) integ = 6'd2;
        else if (mult > 16'd2048) integ = 6'd4;
        else if (mult >= 16'd501) integ = 6'd8;
        else if (mult >= 16'd60)  integ = {quo[3:0], 2'b00};
        else                      integ = {mult[5:2], 2'b00} + 6'd4;
    end
endmodule

// File: rtl/pll_mult_codec.sv
module pll_mult_codec #(
    parameter int LANES = 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        mode,
    input  logic [16:0] din,
    output logic        done,
    output logic [31:0] dout,
    output logic [16:0] factor,
    output logic        bad
);
    import pll_codec_pkg::*;

    regs_t q, d;

    logic [CODE_W-1:0]  lx [LANES+1];
    logic [CNT_W-1:0]   lc [LANES+1];
    logic               end_halt;
    logic [CNT_W-1:0]   bw_mult;
    logic [PROP_W-1:0]  bw_prop;
    logic [INTEG_W-1:0] bw_integ;

    assign lx[0] = q.x;
    assign lc[0] = q.cnt;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        pll_codec_lane u_lane (
            .dec     (q.dec),
            .x_in    (lx[g]),
            .cnt_in  (lc[g]),
            .x_out   (lx[g+1]),
            .cnt_out (lc[g+1])
        );
    end

    assign end_halt = (lc[LANES] == '0) || (q.dec && (lx[LANES] == SEED));
    assign bw_mult  = (q.st == ST_IDLE) ? din[15:0] : q.mult;

    pll_codec_bw u_bw (
        .mult  (bw_mult),
        .prop  (bw_prop),
        .integ (bw_integ)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (start && !q.done) begin
                    d.dec  = mode;
                    d.mult = din[15:0];
                    d.bad  = 1'b0;
                    if (!mode) begin
                        if (din[15:0] <= 16'd2) begin
                            d.done   = 1'b1;
                            d.factor = '0;
                            d.dout   = pack_word((din[15:0] == 16'd0) ? '0 :
                                                 (din[15:0] == 16'd1) ? CODE_M1 : CODE_M2,
                                                 bw_prop, bw_integ);
                        end else begin
                            d.st  = ST_RUN;
                            d.x   = SEED;
                            d.cnt = (din[15:0] > MULT_TOP) ? '0 : CNT_START - din[15:0];
                        end
                    end else if (din == CODE_M1) begin
                        d.done   = 1'b1;
                        d.dout   = 32'd1;
                        d.factor = 17'd2;
                    end else if (din == CODE_M2) begin
                        d.done   = 1'b1;
                        d.dout   = 32'd2;
                        d.factor = 17'd4;
                    end else begin
                        d.st  = ST_RUN;
                        d.x   = din;
                        d.cnt = CNT_START;
                    end
                end
            end
            ST_RUN: begin
                d.x   = lx[LANES];
                d.cnt = lc[LANES];
                if (end_halt) begin
                    d.st   = ST_IDLE;
                    d.done = 1'b1;
                    if (!q.dec) begin
                        d.dout   = pack_word(lx[LANES], bw_prop, bw_integ);
                        d.factor = '0;
                        d.bad    = 1'b0;
                    end else if (lc[LANES] == '0) begin
                        d.dout   = '0;
                        d.factor = '0;
                        d.bad    = 1'b1;
                    end else begin
                        d.dout   = {16'b0, lc[LANES]};
                        d.factor = {lc[LANES], 1'b0};
                        d.bad    = 1'b0;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign done   = q.done;
    assign dout   = q.dout;
    assign factor = q.factor;
    assign bad    = q.bad;

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    bad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bad |-> (dout == '0 && factor == '0));

    // R7
    progress_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_RUN && !end_halt) |=> (q.cnt < $past(q.cnt)));

    // R6
    special_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE && start && !done && mode && din == CODE_M1)
        |=> (done && dout == 32'd1 && factor == 17'd2));

    // R3
    code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !q.dec && q.mult > 16'd2) |-> (dout[16:15] == 2'b00));

    // R8
    factor_twice_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && q.dec && !bad) |-> (factor == {dout[15:0], 1'b0}));
endmodule

// File: tb/pll_mult_codec_bench.sv
`timescale 1ns/1ps
module pll_mult_codec_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        mode = 1'b0;
    logic [16:0] din = '0;
    logic        done;
    logic [31:0] dout;
    logic [16:0] factor;
    logic        bad;

    pll_mult_codec #(.LANES(8)) u_pll_mult_codec (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .din(din),
        .done(done), .dout(dout), .factor(factor), .bad(bad)
    );

    always #4 clk = ~clk;

    typedef struct {
        logic [31:0] dout;
        logic [16:0] fac;
        logic        bad;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int checks = 0, fails = 0, seen = 0, stray = 0, cycles = 0;
    logic prev_done = 1'b0;
    logic ended = 1'b0;

    function automatic logic [16:0] model_code(input int m);
        logic [14:0] x;
        if (m == 0) return 17'h0;
        if (m == 1) return 17'h18003;
        if (m == 2) return 17'h10003;
        x = 15'h4000;
        for (int i = m; i <= 32768; i++) x = {x[0] ^ x[1], x[14:1]};
        return {2'b00, x};
    endfunction

    function automatic int model_prop(input int m);
        return (m < 60) ? (m >> 1) + 1 : 31;
    endfunction

    function automatic int model_integ(input int m);
        int t;
        if (m > 16384) return 1;
        if (m > 8192)  return 2;
        if (m > 2048)  return 4;
        if (m >= 501)  return 8;
        if (m >= 60) begin
            t = 1024 / (m + 9);
            if (t * (m + 9) != 1024) t = t + 1;
            return 4 * t;
        end
        return (m & 60) + 4;
    endfunction

    function automatic logic [31:0] model_word(input int m);
        return {4'b0000, 6'(model_integ(m)), 5'(model_prop(m)), model_code(m)};
    endfunction

    task automatic summary_and_end();
        if (!ended) begin
            ended = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    task automatic check(input bit ok, input string what, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, expv);
        end
    endtask

    // monitor: pops the scoreboard on each result strobe
    always @(negedge clk) begin
        if (rst_n) begin
            if (done && prev_done) check(1'b0, "R10 done longer than one cycle", 1, 0);
            if (done) begin
                if (exp_q.size() == 0) begin
                    stray++;
                    check(1'b0, "R10 result with no accepted request", dout, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(dout == e.dout, {e.tag, " dout"}, dout, e.dout);
                    check(factor == e.fac, {e.tag, " factor"}, factor, e.fac);
                    check(bad == e.bad, {e.tag, " bad"}, bad, e.bad);
                    seen++;
                end
            end
            prev_done = done;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles >= 195000) begin
            check(1'b0, "watchdog expired", cycles, 0);
            summary_and_end();
        end
    end

    task automatic conv(input logic md, input logic [16:0] d, input logic [31:0] ed,
                        input logic [16:0] ef, input logic eb, input string tag,
                        output int lat);
        exp_t e;
        int tgt, t0;
        e.dout = ed; e.fac = ef; e.bad = eb; e.tag = tag;
        exp_q.push_back(e);
        tgt = seen + 1;
        @(negedge clk);
        start = 1'b1; mode = md; din = d;
        t0 = cycles;
        @(negedge clk);
        start = 1'b0;
        wait (seen >= tgt);
        lat = cycles - t0;
    endtask

    task automatic enc(input int m, input string tag, output int lat);
        conv(1'b0, 17'(m), model_word(m), 17'h0, 1'b0, tag, lat);
    endtask

    task automatic dec(input int m, input string tag, output int lat);
        conv(1'b1, model_code(m), 32'(m), 17'(2 * m), 1'b0, tag, lat);
    endtask

    initial begin
        int lat;
        int mlist[7] = '{3, 59, 60, 500, 501, 2049, 32768};
        repeat (3) @(negedge clk);
        // R1 reset state
        check(done == 0 && dout == 0 && factor == 0 && bad == 0, "R1 reset outputs", dout, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(done == 0 && dout == 0 && factor == 0 && bad == 0, "R1 after release", dout, 0);

        // R2 special encodes, one edge latency
        enc(0, "R2 enc 0", lat);
        check(lat == 1, "R2 latency 0", lat, 1);
        enc(1, "R2 enc 1", lat);
        check(lat == 1, "R2 latency 1", lat, 1);
        enc(2, "R2 enc 2", lat);

        // R6 special decodes
        dec(1, "R6 dec 1", lat);
        check(lat == 1, "R6 latency", lat, 1);
        dec(2, "R6 dec 2", lat);

        // R3 R4 R5 encode, R7 R8 decode round trip
        foreach (mlist[i]) begin
            enc(mlist[i], $sformatf("R3 R4 R5 enc %0d", mlist[i]), lat);
            dec(mlist[i], $sformatf("R7 R8 dec %0d", mlist[i]), lat);
        end

        // R9 code that never reaches the seed
        conv(1'b1, 17'h0, 32'h0, 17'h0, 1'b1, "R9 invalid code", lat);

        // R10 start on the done cycle is ignored
        start = 1'b1; mode = 1'b1; din = 17'h18003;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        check(stray == 0, "R10 start on done cycle", stray, 0);

        // R10 start during a walk is ignored
        begin
            exp_t e;
            int tgt;
            e.dout = model_word(30000); e.fac = 0; e.bad = 0; e.tag = "R10 enc 30000";
            exp_q.push_back(e);
            tgt = seen + 1;
            @(negedge clk);
            start = 1'b1; mode = 1'b0; din = 17'd30000;
            @(negedge clk);
            start = 1'b0;
            repeat (10) @(negedge clk);
            start = 1'b1; mode = 1'b1; din = 17'h10003;
            @(negedge clk);
            start = 1'b0;
            wait (seen >= tgt);
            repeat (4) @(negedge clk);
            check(stray == 0, "R10 start during walk", stray, 0);
        end

        summary_and_end();
    end
endmodule